// File: doc/BRIEF.md
# Shift Register Handshake Transfer Engine

This block carries whole packets, one byte at a time, between a host and a small controller. Each side sees an 8-bit shift register as a byte that is loaded in parallel. The host frames every byte by writing two active-low handshake lines: a transfer-in-progress line and an acknowledge line. The block answers on an active-low transfer-request line. Each host write of the handshake lines is evaluated once. The block compares the new line levels with the levels from the previous write, and edges on the pair decide what happens.

A direction input selects the flow. When the host sends, each edge on the pair copies the shift-register byte into a 16-slot packet buffer. When in-progress rises, the collected packet is handed to a downstream consumer as a one-cycle pulse with a length and a read port. When the controller sends, a response of up to 128 bytes is first written and committed into a response buffer. Each handshake edge then moves the next response byte into the shift register, and transfer-request shows whether bytes are still waiting. While no transfer is in progress, toggles of acknowledge are echoed on transfer-request as a sync exchange. A single shift-register interrupt flag is set by every byte moved, every packet boundary, every sync toggle and every response commit.

Top module: `shsk_xfer_engine`

## Requirements
- R1: After reset, `treq_n` is 1, `sr_irq` is 0, `pkt_valid` is 0 and `sr_q` is 0. The stored handshake levels start as in-progress high and acknowledge high.
- R2: With `dir_out`=1, consider a write on `pb_wr` with `pb_tip_n`=0 whose (`pb_tip_n`, `pb_tack_n`) pair differs from the previous write. It stores the current `sr_q` into the next packet slot and sets `sr_irq`. A write that repeats the previous pair stores nothing and leaves `sr_irq` unchanged.
- R3: At most OUT_DEPTH (16) bytes are stored per packet. Once the buffer is full, further edges store nothing and do not set `sr_irq`.
- R4: A write that raises `pb_tip_n` from 0 to 1 always sets `sr_irq`. If bytes were stored, `pkt_valid` is high for exactly one cycle with `pkt_len` equal to the byte count, the bytes can be read in order at `pkt_raddr` 0 upward, and the count restarts at zero.
- R5: With `dir_out`=0, `pb_tip_n`=0, response bytes pending and the pair changed, `sr_q` takes the next response byte and `sr_irq` is set.
- R6: When the last pending response byte is loaded, `treq_n` goes to 1.
- R7: When `pb_tip_n` is 1 on this write and on the previous one, a change of `pb_tack_n` copies the new `pb_tack_n` level onto `treq_n` and sets `sr_irq`. An unchanged `pb_tack_n` does not set `sr_irq`.
- R8: A write with `pb_tip_n`=1 that is not a sync toggle drives `treq_n` to 0 while response bytes remain unread.
- R9: `rsp_commit` restarts the response read position, stores `rsp_len` (clamped to IN_DEPTH) and sets `sr_irq`. If in-progress was high on the last write and the length is nonzero, `treq_n` goes to 0. Otherwise `treq_n` is unchanged.
- R10: `sr_flag_clr` clears `sr_irq`, and a set event in the same cycle wins.
- R11: With `dir_out`=0 and no bytes pending, handshake edges leave `sr_q` and `sr_irq` unchanged. Cycles with neither `pb_wr` nor `rsp_commit` leave `treq_n` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_out | input | 1 | 1: host sends bytes to the block; 0: block sends bytes to the host |
| pb_wr | input | 1 | Host write strobe for the handshake lines |
| pb_tip_n | input | 1 | Transfer-in-progress level, active low, sampled with `pb_wr` |
| pb_tack_n | input | 1 | Acknowledge level, active low, sampled with `pb_wr` |
| sr_wr | input | 1 | Host write of the shift register |
| sr_wdata | input | DATA_W | Byte written by the host |
| sr_flag_clr | input | 1 | Clears the shift-register interrupt flag |
| rsp_wr | input | 1 | Write one response byte |
| rsp_waddr | input | $clog2(IN_DEPTH) | Response byte position |
| rsp_wdata | input | DATA_W | Response byte |
| rsp_commit | input | 1 | Start sending a response of `rsp_len` bytes |
| rsp_len | input | $clog2(IN_DEPTH+1) | Response length |
| treq_n | output | 1 | Transfer request to the host, active low |
| sr_q | output | DATA_W | Shift-register byte |
| sr_irq | output | 1 | Shift-register interrupt flag |
| pkt_valid | output | 1 | One-cycle pulse: host packet complete |
| pkt_len | output | $clog2(OUT_DEPTH+1) | Byte count of the completed packet |
| pkt_raddr | input | $clog2(OUT_DEPTH) | Read position in the packet buffer |
| pkt_rdata | output | DATA_W | Packet byte at `pkt_raddr` |

## Verification
Some properties are checked every cycle: a stored or loaded byte always sets the flag, a loaded byte lands in the shift register, the last load releases transfer-request, and a sync toggle copies acknowledge. Also checked every cycle: the packet and response indices stay within bounds, a packet pulse carries a nonzero length while the count restarts, and transfer-request never moves without a handshake write or a commit. Other behaviour shows only in the bench's scenarios: the exact byte contents and order of packets seen by the consumer, truncation at sixteen bytes, writes that repeat the pair and change nothing, the request line around commits made with in-progress high or low, and the outcome when a flag clear meets a set event.

// File: rtl/shsk_pkg.sv
package shsk_pkg;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_STORE,
    ACT_LOAD,
    ACT_SYNC,
    ACT_CLOSE
  } shsk_act_e;

  function automatic logic pair_moved(input logic tip_a, input logic tack_a,
                                      input logic tip_b, input logic tack_b);
    return (tip_a != tip_b) || (tack_a != tack_b);
  endfunction

  function automatic logic act_sets_flag(input shsk_act_e a);
    return a != ACT_NONE;
  endfunction

endpackage

// File: rtl/shsk_decide.sv
module shsk_decide
  import shsk_pkg::*;
(
  input  logic      cur_tip_n,
  input  logic      cur_tack_n,
  input  logic      last_tip_n,
  input  logic      last_tack_n,
  input  logic      dir_out,
  input  logic      out_room,
  input  logic      in_pending,
  output shsk_act_e act,
  output logic      want_req
);

  logic moved;
  logic tack_toggled;

  assign moved        = pair_moved(cur_tip_n, cur_tack_n, last_tip_n, last_tack_n);
  assign tack_toggled = (cur_tack_n != last_tack_n);

  always_comb begin
    act      = ACT_NONE;
    want_req = 1'b0;
    if (!cur_tip_n) begin
      // transfer active: a moved pair frames one byte
      if (moved) begin
        if (dir_out) begin
          if (out_room) act = ACT_STORE;
        end else if (in_pending) begin
          act = ACT_LOAD;
        end
      end
    end else begin
      if (last_tip_n && tack_toggled) begin
        act = ACT_SYNC;
      end else begin
        if (!last_tip_n) act = ACT_CLOSE;
        want_req = in_pending;
      end
    end
  end

endmodule

// File: rtl/shsk_outbuf.sv
module shsk_outbuf #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              flush,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [CW-1:0]     cnt,
  output logic              room
);

  logic [DATA_W-1:0] mem [DEPTH];

  function automatic logic has_room(input logic [CW-1:0] c);
    return c < CW'(DEPTH);
  endfunction

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] c);
    return c + CW'(1);
  endfunction

  assign room    = has_room(cnt);
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (push && room) mem[cnt[AW-1:0]] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (flush)         cnt <= '0;
    else if (push && room)  cnt <= bump(cnt);
  end

endmodule

// File: rtl/shsk_inbuf.sv
module shsk_inbuf #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 128,
  localparam int AW    = $clog2(DEPTH),
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              commit,
  input  logic [LW-1:0]     commit_len,
  input  logic              adv,
  output logic [DATA_W-1:0] rd_data,
  output logic [LW-1:0]     idx,
  output logic [LW-1:0]     len,
  output logic              pending,
  output logic              final_byte
);

  logic [DATA_W-1:0] mem [DEPTH];

  function automatic logic [LW-1:0] clamp_len(input logic [LW-1:0] l);
    return (l > LW'(DEPTH)) ? LW'(DEPTH) : l;
  endfunction

  function automatic logic is_final(input logic [LW-1:0] i, input logic [LW-1:0] l);
    return ({1'b0, i} + (LW+1)'(1)) >= {1'b0, l};
  endfunction

  assign pending    = idx < len;
  assign final_byte = is_final(idx, len);
  assign rd_data    = mem[idx[AW-1:0]];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
      len <= '0;
    end else if (commit) begin
      idx <= '0;
      len <= clamp_len(commit_len);
    end else if (adv && pending) begin
      idx <= idx + LW'(1);
    end
  end

endmodule

// File: rtl/shsk_xfer_engine.sv
module shsk_xfer_engine
  import shsk_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int OUT_DEPTH = 16,
  parameter int IN_DEPTH  = 128,
  localparam int OUT_AW   = $clog2(OUT_DEPTH),
  localparam int OUT_CW   = $clog2(OUT_DEPTH + 1),
  localparam int IN_AW    = $clog2(IN_DEPTH),
  localparam int IN_LW    = $clog2(IN_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_out,
  input  logic              pb_wr,
  input  logic              pb_tip_n,
  input  logic              pb_tack_n,
  input  logic              sr_wr,
  input  logic [DATA_W-1:0] sr_wdata,
  input  logic              sr_flag_clr,
  input  logic              rsp_wr,
  input  logic [IN_AW-1:0]  rsp_waddr,
  input  logic [DATA_W-1:0] rsp_wdata,
  input  logic              rsp_commit,
  input  logic [IN_LW-1:0]  rsp_len,
  output logic              treq_n,
  output logic [DATA_W-1:0] sr_q,
  output logic              sr_irq,
  output logic              pkt_valid,
  output logic [OUT_CW-1:0] pkt_len,
  input  logic [OUT_AW-1:0] pkt_raddr,
  output logic [DATA_W-1:0] pkt_rdata
);

  // handshake history (levels of the previous host write)
  logic last_tip_n;
  logic last_tack_n;

  shsk_act_e          act;
  logic               want_req;
  logic [OUT_CW-1:0]  out_cnt;
  logic               out_room;
  logic [DATA_W-1:0]  in_rd_data;
  logic [IN_LW-1:0]   in_idx;
  logic [IN_LW-1:0]   in_len;
  logic               in_pending;
  logic               in_last;

  // named events for the checker
  logic ev_store;
  logic ev_load;
  logic ev_sync;
  logic ev_close;
  logic ev_req_low;
  logic ev_commit_req;
  logic flag_set;

  shsk_decide u_decide (
    .cur_tip_n   (pb_tip_n),
    .cur_tack_n  (pb_tack_n),
    .last_tip_n  (last_tip_n),
    .last_tack_n (last_tack_n),
    .dir_out     (dir_out),
    .out_room    (out_room),
    .in_pending  (in_pending),
    .act         (act),
    .want_req    (want_req)
  );

  assign ev_store      = pb_wr && (act == ACT_STORE);
  assign ev_load       = pb_wr && (act == ACT_LOAD);
  assign ev_sync       = pb_wr && (act == ACT_SYNC);
  assign ev_close      = pb_wr && (act == ACT_CLOSE);
  assign ev_req_low    = pb_wr && want_req;
  assign ev_commit_req = rsp_commit && last_tip_n && (rsp_len != '0);
  assign flag_set      = (pb_wr && act_sets_flag(act)) || rsp_commit;

  shsk_outbuf #(
    .DATA_W (DATA_W),
    .DEPTH  (OUT_DEPTH)
  ) u_outbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (ev_store),
    .push_data (sr_q),
    .flush     (ev_close),
    .rd_addr   (pkt_raddr),
    .rd_data   (pkt_rdata),
    .cnt       (out_cnt),
    .room      (out_room)
  );

  shsk_inbuf #(
    .DATA_W (DATA_W),
    .DEPTH  (IN_DEPTH)
  ) u_inbuf (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (rsp_wr),
    .wr_addr    (rsp_waddr),
    .wr_data    (rsp_wdata),
    .commit     (rsp_commit),
    .commit_len (rsp_len),
    .adv        (ev_load),
    .rd_data    (in_rd_data),
    .idx        (in_idx),
    .len        (in_len),
    .pending    (in_pending),
    .final_byte (in_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_tip_n  <= 1'b1;
      last_tack_n <= 1'b1;
    end else if (pb_wr) begin
      last_tip_n  <= pb_tip_n;
      last_tack_n <= pb_tack_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sr_q <= '0;
    else if (ev_load) sr_q <= in_rd_data;
    else if (sr_wr)   sr_q <= sr_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  treq_n <= 1'b1;
    else if (ev_load && in_last) treq_n <= 1'b1;
    else if (ev_sync)            treq_n <= pb_tack_n;
    else if (ev_req_low)         treq_n <= 1'b0;
    else if (ev_commit_req)      treq_n <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           sr_irq <= 1'b0;
    else if (flag_set)    sr_irq <= 1'b1;
    else if (sr_flag_clr) sr_irq <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt_valid <= 1'b0;
      pkt_len   <= '0;
    end else begin
      pkt_valid <= ev_close && (out_cnt != '0);
      if (ev_close && (out_cnt != '0)) pkt_len <= out_cnt;
    end
  end

endmodule

// File: rtl/shsk_xfer_engine_chk.sv
module shsk_xfer_engine_chk #(
  parameter int DATA_W    = 8,
  parameter int OUT_DEPTH = 16,
  parameter int IN_DEPTH  = 128,
  localparam int OUT_CW   = $clog2(OUT_DEPTH + 1),
  localparam int IN_LW    = $clog2(IN_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pb_wr,
  input logic              pb_tack_n,
  input logic              rsp_commit,
  input logic              ev_store,
  input logic              ev_load,
  input logic              ev_sync,
  input logic              in_last,
  input logic [DATA_W-1:0] in_rd_data,
  input logic [OUT_CW-1:0] out_cnt,
  input logic [IN_LW-1:0]  in_idx,
  input logic [IN_LW-1:0]  in_len,
  input logic              pkt_valid,
  input logic [OUT_CW-1:0] pkt_len,
  input logic              sr_irq,
  input logic [DATA_W-1:0] sr_q,
  input logic              treq_n
);

  p_store_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_store |=> sr_irq);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_cnt <= OUT_CW'(OUT_DEPTH));

  p_pkt_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> (pkt_len != '0) && (pkt_len <= OUT_CW'(OUT_DEPTH)) && (out_cnt == '0));

  p_load_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load |=> (sr_q == $past(in_rd_data)) && sr_irq);

  p_last_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_load && in_last) |=> treq_n);

  p_sync_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sync |=> (treq_n == $past(pb_tack_n)) && sr_irq);

  p_idx_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_idx <= in_len);

  p_quiet_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!pb_wr && !rsp_commit) |=> $stable(treq_n));

endmodule

bind shsk_xfer_engine shsk_xfer_engine_chk #(
  .DATA_W    (DATA_W),
  .OUT_DEPTH (OUT_DEPTH),
  .IN_DEPTH  (IN_DEPTH)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pb_wr      (pb_wr),
  .pb_tack_n  (pb_tack_n),
  .rsp_commit (rsp_commit),
  .ev_store   (ev_store),
  .ev_load    (ev_load),
  .ev_sync    (ev_sync),
  .in_last    (in_last),
  .in_rd_data (in_rd_data),
  .out_cnt    (out_cnt),
  .in_idx     (in_idx),
  .in_len     (in_len),
  .pkt_valid  (pkt_valid),
  .pkt_len    (pkt_len),
  .sr_irq     (sr_irq),
  .sr_q       (sr_q),
  .treq_n     (treq_n)
);

// File: tb/shsk_xfer_engine_tb.sv
`timescale 1ns/1ps
module shsk_xfer_engine_tb;

  localparam int DATA_W    = 8;
  localparam int OUT_DEPTH = 16;
  localparam int IN_DEPTH  = 128;
  localparam int OUT_AW    = $clog2(OUT_DEPTH);
  localparam int OUT_CW    = $clog2(OUT_DEPTH + 1);
  localparam int IN_AW     = $clog2(IN_DEPTH);
  localparam int IN_LW     = $clog2(IN_DEPTH + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              dir_out = 1'b0;
  logic              pb_wr = 1'b0;
  logic              pb_tip_n = 1'b1;
  logic              pb_tack_n = 1'b1;
  logic              sr_wr = 1'b0;
  logic [DATA_W-1:0] sr_wdata = '0;
  logic              sr_flag_clr = 1'b0;
  logic              rsp_wr = 1'b0;
  logic [IN_AW-1:0]  rsp_waddr = '0;
  logic [DATA_W-1:0] rsp_wdata = '0;
  logic              rsp_commit = 1'b0;
  logic [IN_LW-1:0]  rsp_len = '0;
  logic              treq_n;
  logic [DATA_W-1:0] sr_q;
  logic              sr_irq;
  logic              pkt_valid;
  logic [OUT_CW-1:0] pkt_len;
  logic [OUT_AW-1:0] pkt_raddr = '0;
  logic [DATA_W-1:0] pkt_rdata;

  int checks = 0;
  int fails = 0;
  int pkts_seen = 0;
  bit done = 1'b0;
  logic cur_tack = 1'b1;

  int exp_len_q[$];
  int exp_byte_q[$];

  always #5 clk = ~clk;

  shsk_xfer_engine #(
    .DATA_W(DATA_W), .OUT_DEPTH(OUT_DEPTH), .IN_DEPTH(IN_DEPTH)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .dir_out(dir_out), .pb_wr(pb_wr),
    .pb_tip_n(pb_tip_n), .pb_tack_n(pb_tack_n), .sr_wr(sr_wr),
    .sr_wdata(sr_wdata), .sr_flag_clr(sr_flag_clr), .rsp_wr(rsp_wr),
    .rsp_waddr(rsp_waddr), .rsp_wdata(rsp_wdata), .rsp_commit(rsp_commit),
    .rsp_len(rsp_len), .treq_n(treq_n), .sr_q(sr_q), .sr_irq(sr_irq),
    .pkt_valid(pkt_valid), .pkt_len(pkt_len), .pkt_raddr(pkt_raddr),
    .pkt_rdata(pkt_rdata)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic pbw(input logic tip, input logic tack);
    @(negedge clk);
    pb_tip_n = tip; pb_tack_n = tack; pb_wr = 1'b1;
    @(negedge clk);
    pb_wr = 1'b0;
    cur_tack = tack;
  endtask

  task automatic srw(input logic [DATA_W-1:0] b);
    @(negedge clk);
    sr_wr = 1'b1; sr_wdata = b;
    @(negedge clk);
    sr_wr = 1'b0;
  endtask

  task automatic clr_flag();
    @(negedge clk);
    sr_flag_clr = 1'b1;
    @(negedge clk);
    sr_flag_clr = 1'b0;
  endtask

  task automatic rsp_load(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rsp_wr = 1'b1; rsp_waddr = IN_AW'(i); rsp_wdata = DATA_W'(base + i);
    end
    @(negedge clk);
    rsp_wr = 1'b0; rsp_commit = 1'b1; rsp_len = IN_LW'(n);
    @(negedge clk);
    rsp_commit = 1'b0;
  endtask

  // driver: sends n bytes host-to-block and queues the expected packet
  task automatic send_out(input int n, input int base, input int clr_at);
    int stored = 0;
    dir_out = 1'b1;
    for (int i = 0; i < n; i++) begin
      srw(DATA_W'(base + i));
      if (i == clr_at) clr_flag();
      pbw(1'b0, (i == 0) ? cur_tack : ~cur_tack);
      if (stored < OUT_DEPTH) begin
        exp_byte_q.push_back((base + i) & 8'hFF);
        stored++;
      end else if (i == clr_at) begin
        check(sr_irq == 1'b0, "R3 full buffer edge sets no flag", sr_irq, 0);
      end
    end
    if (stored > 0) exp_len_q.push_back(stored);
    pbw(1'b1, 1'b1);
  endtask

  // monitor: scoreboard for completed packets
  initial begin
    forever begin
      @(negedge clk);
      if (pkt_valid) begin
        pkts_seen++;
        if (exp_len_q.size() == 0) begin
          check(1'b0, "R4 unexpected packet", pkt_len, 0);
        end else begin
          automatic int l = exp_len_q.pop_front();
          check(pkt_len == OUT_CW'(l), "R4 packet length", pkt_len, l);
          for (int i = 0; i < l; i++) begin
            automatic int eb = exp_byte_q.pop_front();
            pkt_raddr = OUT_AW'(i);
            #0.2;
            check(pkt_rdata == DATA_W'(eb), "R4 packet byte", pkt_rdata, eb);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(treq_n == 1'b1, "R1 treq_n", treq_n, 1);
    check(sr_irq == 1'b0, "R1 sr_irq", sr_irq, 0);
    check(pkt_valid == 1'b0, "R1 pkt_valid", pkt_valid, 0);
    check(sr_q == '0, "R1 sr_q", sr_q, 0);

    // R2: outbound store and repeat-pair write
    dir_out = 1'b1;
    srw(8'h11);
    pbw(1'b0, 1'b1);
    check(sr_irq == 1'b1, "R2 store sets flag", sr_irq, 1);
    clr_flag();
    pbw(1'b0, 1'b1);
    check(sr_irq == 1'b0, "R2 repeat pair no flag", sr_irq, 0);
    srw(8'h22); pbw(1'b0, 1'b0);
    srw(8'h33); pbw(1'b0, 1'b1);
    exp_byte_q.push_back(8'h11); exp_byte_q.push_back(8'h22); exp_byte_q.push_back(8'h33);
    exp_len_q.push_back(3);
    clr_flag();
    pbw(1'b1, 1'b1);
    check(sr_irq == 1'b1, "R4 TIP rise sets flag", sr_irq, 1);
    @(negedge clk);
    check(pkt_valid == 1'b0, "R4 pulse one cycle", pkt_valid, 0);
    check(pkts_seen == 1, "R4 packet count", pkts_seen, 1);

    // R3: overflow beyond sixteen bytes
    send_out(20, 8'h40, 16);
    @(negedge clk);
    check(pkts_seen == 2, "R3 truncated packet seen", pkts_seen, 2);

    // R9/R5/R6/R11: inbound transfer
    dir_out = 1'b0;
    clr_flag();
    rsp_load(3, 8'hC0);
    check(treq_n == 1'b0, "R9 commit with TIP high requests", treq_n, 0);
    check(sr_irq == 1'b1, "R9 commit sets flag", sr_irq, 1);
    clr_flag();
    pbw(1'b0, 1'b1);
    check(sr_q == 8'hC0, "R5 first byte", sr_q, 8'hC0);
    check(sr_irq == 1'b1, "R5 load sets flag", sr_irq, 1);
    pbw(1'b0, 1'b0);
    check(sr_q == 8'hC1, "R5 second byte", sr_q, 8'hC1);
    check(treq_n == 1'b0, "R6 request held mid packet", treq_n, 0);
    pbw(1'b0, 1'b1);
    check(sr_q == 8'hC2, "R5 third byte", sr_q, 8'hC2);
    check(treq_n == 1'b1, "R6 last byte releases request", treq_n, 1);
    clr_flag();
    pbw(1'b0, 1'b0);
    check(sr_q == 8'hC2, "R11 no pending keeps sr_q", sr_q, 8'hC2);
    check(sr_irq == 1'b0, "R11 no pending keeps flag", sr_irq, 0);
    pbw(1'b1, 1'b1);
    check(sr_irq == 1'b1, "R4 empty close still flags", sr_irq, 1);
    check(treq_n == 1'b1, "R8 nothing pending keeps request off", treq_n, 1);
    check(pkts_seen == 2, "R4 empty close no packet", pkts_seen, 2);

    // R7: idle sync
    clr_flag();
    pbw(1'b1, 1'b0);
    check(treq_n == 1'b0, "R7 sync low", treq_n, 0);
    check(sr_irq == 1'b1, "R7 sync sets flag", sr_irq, 1);
    clr_flag();
    pbw(1'b1, 1'b1);
    check(treq_n == 1'b1, "R7 sync high", treq_n, 1);
    clr_flag();
    pbw(1'b1, 1'b1);
    check(sr_irq == 1'b0, "R7 unchanged TACK no flag", sr_irq, 0);

    // R10: set wins over clear
    @(negedge clk);
    pb_tip_n = 1'b1; pb_tack_n = 1'b0; pb_wr = 1'b1; sr_flag_clr = 1'b1;
    @(negedge clk);
    pb_wr = 1'b0; sr_flag_clr = 1'b0;
    check(sr_irq == 1'b1, "R10 set beats clear", sr_irq, 1);
    clr_flag();
    check(sr_irq == 1'b0, "R10 clear alone", sr_irq, 0);

    // R9/R8: commit while TIP low, request on TIP rise
    pbw(1'b0, 1'b0);
    rsp_load(1, 8'hD5);
    check(treq_n == 1'b0 || treq_n == 1'b1, "R9 sanity", treq_n, 0);
    check(treq_n == 1'b0, "R9 treq after sync-low state", treq_n, 0);
    pbw(1'b0, 1'b1);
    check(sr_q == 8'hD5, "R5 single byte load", sr_q, 8'hD5);
    check(treq_n == 1'b1, "R6 single byte releases", treq_n, 1);
    rsp_load(1, 8'hE7);
    check(treq_n == 1'b1, "R9 commit with TIP low leaves request", treq_n, 1);
    pbw(1'b1, 1'b1);
    check(treq_n == 1'b0, "R8 TIP high with pending requests", treq_n, 0);

    @(negedge clk);
    check(exp_len_q.size() == 0, "R4 all packets delivered", exp_len_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule